// File: doc/BRIEF.md
# Serial Receive Character Queue with Overrun Protection

This block is the character queue that sits between the receive shifter of a 16550-style serial port and the host. Each byte the shifter assembles is pushed into the queue. Each host read of the receive buffer register pops the oldest byte. The byte appears on a registered read-data output one cycle after the pop. The block reports its occupancy, a data-ready indication and two sticky line-status flags: overrun and break.

When the queue is in receive mode and already holds `DEPTH` bytes, a new byte is refused. The stored bytes stay as they were and the overrun flag rises. It stays up until the host reads line status. That same line-status read strobe also clears the break flag, which the framing logic sets through a pulse input.

A mode input switches the queue to transmit behaviour. In that mode a push is never refused: it is written at the write position and the write position advances, while the occupancy stays pinned at `DEPTH`. Serial framing, baud timing and interrupt encoding belong to neighbouring blocks.

Top module: `serial_rx_fifo`

## Requirements
- R1: Popped bytes come out in the order they were pushed, across any number of pointer wraps. A pop of a non-empty queue loads the oldest byte onto `rd_data` at the clock edge that accepts the pop. The byte is therefore visible in the following cycle.
- R2: In receive mode (`tx_mode`=0), a push without a pop while occupancy equals `DEPTH` is discarded. The `DEPTH` stored bytes are later popped unchanged.
- R3: Such a refused receive push sets `overrun` at the next edge. The flag stays set through any number of later pushes and pops until a line-status read clears it.
- R4: `occupancy` rises by one for each accepted push and falls by one for each accepted pop. It never exceeds `DEPTH`.
- R5: In transmit mode (`tx_mode`=1), a push while full and without a pop writes the byte at the write position and advances it. Because the write position equals the read position when full, the next pop returns that new byte. `occupancy` stays at `DEPTH` and `overrun` does not change.
- R6: `data_ready` is 1 exactly when `occupancy` is nonzero. It falls in the cycle after the pop that empties the queue.
- R7: A push and a pop in the same cycle on a full receive queue are both accepted, because the pop is taken first. `occupancy` stays at `DEPTH`, `overrun` is not set, and the pushed byte is delivered later in order.
- R8: A cycle with `lsr_rd`=1 clears both `overrun` and `brk_flag` at the next edge. A new overrun or break event in that same cycle wins, and its flag stays set.
- R9: A pop while `occupancy` is 0 is ignored: the occupancy stays 0 and `rd_data` keeps its previous value. A push and a pop on an empty queue store the pushed byte.
- R10: After a synchronous reset, `occupancy`, `data_ready`, `overrun`, `brk_flag` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 0: receive policy (refuse when full), 1: transmit policy (always write) |
| push | input | 1 | Push strobe from the shifter |
| push_data | input | WIDTH | Byte to store |
| pop | input | 1 | Host read of the receive buffer register |
| lsr_rd | input | 1 | Host read of line status; clears the sticky flags |
| brk_evt | input | 1 | Break-condition pulse from the framing logic |
| rd_data | output | WIDTH | Byte delivered by the last accepted pop (registered) |
| occupancy | output | $clog2(DEPTH)+1 | Number of stored bytes |
| data_ready | output | 1 | Queue is non-empty |
| overrun | output | 1 | Sticky receive overrun flag |
| brk_flag | output | 1 | Sticky break flag |

## Verification
The hardest states to reach are those at the full boundary. These include a refused push that must leave sixteen earlier bytes untouched, a same-cycle push and pop exactly at full, and a transmit-mode overwrite that must then be read back in the right slot. The bench reaches them with a sweep that fills the queue to every level from empty to full. At each level it applies a combined push and pop and then drains the queue, checking each byte against a bench-side queue model. Directed passes then hold the queue full while refusing, overwriting, and colliding a line-status read with new flag events. A long mixed run with mode changes follows, to push the pointers through many wraps.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;

  // Pointer width for a queue of the given depth (at least one bit).
  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Count width: must be able to hold the value DEPTH itself.
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } fifo_mode_e;

endpackage

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_mode,
  input  logic             push,
  input  logic             pop_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             ovr_evt
);
  import serial_fifo_pkg::*;

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic             pop_ok, full_hold, grow;
  fifo_mode_e       mode;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + PTR_W'(1);
  endfunction

  assign mode = fifo_mode_e'(tx_mode);

  // The pop is taken first, so a full queue with a pop in the same cycle has room.
  always_comb begin
    pop_ok    = pop_req && (cnt_q != '0);
    full_hold = (cnt_q == FULL_C) && !pop_ok;
    grow      = push && !full_hold;
    wr_en     = push && ((mode == MODE_TX) || !full_hold);
    ovr_evt   = push && (mode == MODE_RX) && full_hold;
    cnt_next  = cnt_q + CNT_W'(grow) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en)  head_q <= step_ptr(head_q);
      if (pop_ok) tail_q <= step_ptr(tail_q);
      cnt_q <= cnt_next;
    end
  end

  assign wr_addr = head_q;
  assign rd_addr = tail_q;
  assign rd_en   = pop_ok;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port array: no reset on the array, so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port with a synchronous reset on the output register.
  // Read happens before write on a shared address (old data returned).
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/sfifo_status.sv
module sfifo_status #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             ovr_evt,
  input  logic             brk_evt,
  input  logic             lsr_rd,
  output logic             data_ready,
  output logic             overrun,
  output logic             brk_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      overrun    <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      data_ready <= (cnt_next != '0);
      // A new event in the read cycle takes precedence over the clear.
      if (ovr_evt)     overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
      if (brk_evt)     brk_flag <= 1'b1;
      else if (lsr_rd) brk_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = serial_fifo_pkg::ptr_bits(DEPTH),
  localparam int CNT_W = serial_fifo_pkg::cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_mode,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             lsr_rd,
  input  logic             brk_evt,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] occupancy,
  output logic             data_ready,
  output logic             overrun,
  output logic             brk_flag
);
  logic             wr_en, rd_en, ovr_evt;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0] cnt_q, cnt_next;

  sfifo_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .push(push), .pop_req(pop),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .ovr_evt(ovr_evt)
  );

  sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(push_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sfifo_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst), .cnt_next(cnt_next), .ovr_evt(ovr_evt),
    .brk_evt(brk_evt), .lsr_rd(lsr_rd),
    .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag)
  );

  assign occupancy = cnt_q;

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_mode,
  input logic             push,
  input logic             pop,
  input logic             lsr_rd,
  input logic             brk_evt,
  input logic [CNT_W-1:0] occupancy,
  input logic             data_ready,
  input logic             overrun,
  input logic             brk_flag
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    occupancy <= FULL_C); // R4

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
    data_ready == (occupancy != '0)); // R6

  AST_RX_REFUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !tx_mode && occupancy == FULL_C) |=> overrun); // R3

  AST_RX_REFUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !tx_mode && occupancy == FULL_C) |=> $stable(occupancy)); // R2

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !lsr_rd) |=> overrun); // R3

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !brk_evt && !push) |=> (!overrun && !brk_flag)); // R8

  AST_TX_NO_OVR: assert property (@(posedge clk) disable iff (rst)
    (tx_mode && !overrun) |=> !overrun); // R5

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
    (push && pop && occupancy == FULL_C && !overrun && !lsr_rd) |=>
      (occupancy == FULL_C && !overrun)); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && occupancy == '0) |=> (occupancy == '0)); // R9

endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_mode(tx_mode), .push(push), .pop(pop),
  .lsr_rd(lsr_rd), .brk_evt(brk_evt), .occupancy(occupancy),
  .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag)
);

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_mode = 1'b0, push = 1'b0, pop = 1'b0, lsr_rd = 1'b0, brk_evt = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] rd_data;
  logic [4:0] occupancy;
  logic       data_ready, overrun, brk_flag;

  int errors = 0, checks = 0;
  bit done = 0;

  // Bench-side queue model
  int mq [D];
  int mhead = 0, mtail = 0, mcnt = 0, exp_rd = 0;
  bit movr = 0, mbrk = 0;

  always #4 clk = ~clk; // 125 MHz

  serial_rx_fifo u_dut (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .push(push), .push_data(push_data),
    .pop(pop), .lsr_rd(lsr_rd), .brk_evt(brk_evt), .rd_data(rd_data),
    .occupancy(occupancy), .data_ready(data_ready), .overrun(overrun),
    .brk_flag(brk_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R4 occupancy", int'(occupancy), mcnt);
    check("R6 data_ready", int'(data_ready), (mcnt != 0) ? 1 : 0);
    check("R3 overrun", int'(overrun), int'(movr));
    check("R8 brk_flag", int'(brk_flag), int'(mbrk));
    check("R1 rd_data", int'(rd_data), exp_rd);
  endtask

  // Called at a negative edge; drives inputs, advances one clock, checks.
  task automatic step(input bit p, input int d, input bit q, input bit l,
                      input bit b, input bit x);
    bit pop_ok, full_hold;
    push = p; push_data = 8'(d); pop = q; lsr_rd = l; brk_evt = b; tx_mode = x;
    @(posedge clk);
    pop_ok    = q && (mcnt != 0);
    full_hold = (mcnt == D) && !pop_ok;
    if (pop_ok) begin
      exp_rd = mq[mtail];
      mtail  = (mtail + 1) % D;
    end
    if (p && (x || !full_hold)) begin
      mq[mhead] = d & 255;
      mhead = (mhead + 1) % D;
    end
    mcnt = mcnt - (pop_ok ? 1 : 0) + ((p && !full_hold) ? 1 : 0);
    if (p && !x && full_hold) movr = 1;
    else if (l) movr = 0;
    if (b) mbrk = 1;
    else if (l) mbrk = 0;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push = 0; pop = 0; lsr_rd = 0; brk_evt = 0; tx_mode = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mhead = 0; mtail = 0; mcnt = 0; exp_rd = 0; movr = 0; mbrk = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    do_reset();
    check("R10 occupancy", int'(occupancy), 0);
    check("R10 data_ready", int'(data_ready), 0);
    check("R10 overrun", int'(overrun), 0);
    check("R10 brk_flag", int'(brk_flag), 0);
    check("R10 rd_data", int'(rd_data), 0);

    // R9: pop on empty is ignored
    step(0, 0, 1, 0, 0, 0);
    check("R9 empty pop count", int'(occupancy), 0);

    // Sweep every fill level: fill, combined push+pop, drain (R1 R4 R6 R7 R9)
    for (int k = 0; k <= D; k++) begin
      do_reset();
      for (int i = 0; i < k; i++) step(1, k * 16 + i, 0, 0, 0, 0);
      step(1, 200 + k, 1, 0, 0, 0);
      if (k == D) begin
        check("R7 full swap count", int'(occupancy), D);
        check("R7 full swap no overrun", int'(overrun), 0);
      end
      while (mcnt > 0) step(0, 0, 1, 0, 0, 0);
      check("R6 drained ready", int'(data_ready), 0);
      step(0, 0, 1, 0, 0, 0); // R9: rd_data holds
    end

    // R2/R3: refuse when full in receive mode, keep contents, sticky flag
    do_reset();
    for (int i = 0; i < D; i++) step(1, 16 + i, 0, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0, 0);
    check("R3 overrun set", int'(overrun), 1);
    check("R2 count held", int'(occupancy), D);
    step(1, 8'hEF, 0, 0, 0, 0);
    for (int i = 0; i < D; i++) begin
      step(0, 0, 1, 0, 0, 0);
      check("R2 stored byte intact", int'(rd_data), 16 + i);
    end
    check("R3 overrun held after drain", int'(overrun), 1);
    step(0, 0, 0, 1, 0, 0);
    check("R8 overrun cleared", int'(overrun), 0);

    // R8: break set, cleared by read; event during read wins
    step(0, 0, 0, 0, 1, 0);
    check("R8 break set", int'(brk_flag), 1);
    step(0, 0, 0, 1, 1, 0);
    check("R8 break event wins over read", int'(brk_flag), 1);
    step(0, 0, 0, 1, 0, 0);
    check("R8 break cleared", int'(brk_flag), 0);
    for (int i = 0; i < D; i++) step(1, i, 0, 0, 0, 0);
    step(1, 8'h55, 0, 1, 0, 0);
    check("R8 overrun event wins over read", int'(overrun), 1);

    // R5: transmit mode overwrite at the write position
    do_reset();
    for (int i = 0; i < D; i++) step(1, i, 0, 0, 0, 1);
    step(1, 8'hAA, 0, 0, 0, 1);
    check("R5 count stays full", int'(occupancy), D);
    check("R5 no overrun", int'(overrun), 0);
    step(0, 0, 1, 0, 0, 1);
    check("R5 new byte read first", int'(rd_data), 8'hAA);
    step(0, 0, 1, 0, 0, 1);
    check("R5 following byte", int'(rd_data), 1);

    // Long mixed run with mode changes and pointer wraps (R1 R3 R4 R5 R8)
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom % 100;
      automatic bit x = ((n / 250) % 3) == 2;
      automatic bit p = ((n / 500) % 2 == 0) ? (r < 60) : (r < 40);
      automatic bit q = ((n / 500) % 2 == 0) ? (($urandom % 100) < 40) : (($urandom % 100) < 60);
      step(p, $urandom % 256, q, ($urandom % 100) < 4, ($urandom % 100) < 3, x);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule